// File: doc/BRIEF.md
# Programmable Single/Periodic Expiry Timer

This block is a host-programmed interval timer. The host writes one configuration byte that holds a 7-bit count and a mode bit. The time to expiry is the count multiplied by a fixed base tick of 100 ms. A parameter sets how many system clock cycles make up one base tick, so a simulation can run with a short tick.

Writing the configuration does not start the timer. The host then pulses a separate start input. While the timer runs, the read port shows the remaining count, which drops by one on every base tick. When the count runs out, the block raises a one-cycle expiry pulse, which a sticky status bit elsewhere captures. In single mode the timer then stops. In periodic mode it reloads the programmed count and keeps going. Rewriting the configuration halts a running timer.

Top module: `expiry_timer`

## Requirements
- R1: A configuration write (`cfg_wr` high) never starts the timer. After the write, `cnt_rd` stays 0 and `expire` stays low until a start pulse arrives.
- R2: A start pulse with a nonzero programmed count makes `cnt_rd` equal the programmed count N in the next cycle. After that, `cnt_rd` falls by one every TICK_CYCLES cycles, counted from the start edge.
- R3: Single mode (`cfg_data[7]` = 0) raises `expire` exactly N*TICK_CYCLES cycles after the start edge. In that same cycle `cnt_rd` reads 0, and no further pulse follows.
- R4: Periodic mode (`cfg_data[7]` = 1) raises `expire` every N*TICK_CYCLES cycles after the start edge. At each pulse `cnt_rd` reloads to N.
- R5: `expire` is high for exactly one clock cycle per expiry.
- R6: A configuration write halts a running timer. From the next cycle `cnt_rd` reads 0 and no pulse is raised. When a write and a start arrive in the same cycle, the write wins and the timer stays idle.
- R7: A start pulse while the programmed count (`cfg_data[6:0]`) is zero is ignored. `cnt_rd` stays 0 and no pulse is ever raised.
- R8: After reset, and before any start, `cnt_rd` reads 0 and `expire` is low.
- R9: A start pulse clears the base-tick prescaler. A start while the timer runs therefore reloads N, and the next expiry comes a full N*TICK_CYCLES cycles after the new start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_data | input | COUNT_W+1 | Bit COUNT_W is the mode (1 = periodic); the lower bits are the count |
| start | input | 1 | Start command strobe |
| cnt_rd | output | COUNT_W | Remaining count while running, otherwise 0 |
| expire | output | 1 | One-cycle expiry pulse |

## Verification
The assertions assume the strobes are synchronous to `clk`. They also assume TICK_CYCLES is at least 2, which is checked at elaboration, so two ticks or two expiries can never fall in adjacent cycles. The bench drives every input on the falling edge and samples on the falling edge. It draws counts from 1 to 8 and a random mode from a fixed-seed generator, and keeps each strobe to a single cycle. Directed cases cover a zero count, a write and a start in the same cycle, a restart in the middle of a run, and a rewrite that halts a periodic run.

// File: rtl/expiry_timer_pkg.sv
package expiry_timer_pkg;
   typedef enum logic {
      TMODE_ONCE   = 1'b0,
      TMODE_REPEAT = 1'b1
   } tmode_e;
endpackage

// File: rtl/expiry_timer_prescale.sv
module expiry_timer_prescale #(
   parameter int TICK_CYCLES = 10_000_000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic en,
   output logic tick
);
   localparam int PW = (TICK_CYCLES > 2) ? $clog2(TICK_CYCLES) : 1;
   localparam logic [PW-1:0] LAST = PW'(TICK_CYCLES - 1);

   if (TICK_CYCLES < 2) begin : g_bad_tick
      $error("TICK_CYCLES must be at least 2");
   end

   logic [PW-1:0] pre_q;

   assign tick = en && !clr && (pre_q == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             pre_q <= '0;
      else if (clr || !en)    pre_q <= '0;
      else if (pre_q == LAST) pre_q <= '0;
      else                    pre_q <= pre_q + 1'b1;
   end

   // R9: ticks are always separated by the full prescale period
   a_r9_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> !tick);
   a_r9_clr_restarts: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> !tick);
endmodule

// File: rtl/expiry_timer_down.sv
module expiry_timer_down #(
   parameter int COUNT_W = 7
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               halt,
   input  logic               launch,
   input  logic               tick,
   input  logic               repeat_en,
   input  logic [COUNT_W-1:0] load_val,
   output logic               running,
   output logic [COUNT_W-1:0] remain,
   output logic               expire
);
   localparam logic [COUNT_W-1:0] ONE = COUNT_W'(1);

   logic run_q, exp_q;
   logic [COUNT_W-1:0] cur_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q <= 1'b0;
         cur_q <= '0;
         exp_q <= 1'b0;
      end else begin
         exp_q <= 1'b0;
         if (halt) begin
            run_q <= 1'b0;
            cur_q <= '0;
         end else if (launch) begin
            run_q <= 1'b1;
            cur_q <= load_val;
         end else if (run_q && tick) begin
            if (cur_q == ONE) begin
               exp_q <= 1'b1;
               if (repeat_en) cur_q <= load_val;
               else begin
                  run_q <= 1'b0;
                  cur_q <= '0;
               end
            end else begin
               cur_q <= cur_q - ONE;
            end
         end
      end
   end

   assign running = run_q;
   assign remain  = cur_q;
   assign expire  = exp_q;

   // R2: one decrement per tick
   a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
      (run_q && tick && cur_q > ONE && !halt && !launch) |=> (cur_q == $past(cur_q) - ONE));
   // R3: single mode stops at expiry
   a_r3_single_stop: assert property (@(posedge clk) disable iff (!rst_n)
      (run_q && tick && cur_q == ONE && !repeat_en && !halt && !launch) |=> (!run_q && cur_q == '0 && exp_q));
   // R4: periodic mode reloads at expiry
   a_r4_reload: assert property (@(posedge clk) disable iff (!rst_n)
      (run_q && tick && cur_q == ONE && repeat_en && !halt && !launch) |=> (run_q && exp_q && cur_q == $past(load_val)));
endmodule

// File: rtl/expiry_timer.sv
module expiry_timer
   import expiry_timer_pkg::*;
#(
   parameter int COUNT_W     = 7,
   parameter int TICK_CYCLES = 10_000_000
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cfg_wr,
   input  logic [COUNT_W:0]   cfg_data,
   input  logic               start,
   output logic [COUNT_W-1:0] cnt_rd,
   output logic               expire
);
   if (COUNT_W < 1) begin : g_bad_width
      $error("COUNT_W must be at least 1");
   end

   logic [COUNT_W-1:0] cfg_cnt_q;
   tmode_e             cfg_mode_q;
   logic               launch, tick, running;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_cnt_q  <= '0;
         cfg_mode_q <= TMODE_ONCE;
      end else if (cfg_wr) begin
         cfg_cnt_q  <= cfg_data[COUNT_W-1:0];
         cfg_mode_q <= tmode_e'(cfg_data[COUNT_W]);
      end
   end

   assign launch = start && !cfg_wr && (cfg_cnt_q != '0);

   expiry_timer_prescale #(.TICK_CYCLES(TICK_CYCLES)) u_pre (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (launch),
      .en    (running),
      .tick  (tick)
   );

   expiry_timer_down #(.COUNT_W(COUNT_W)) u_down (
      .clk       (clk),
      .rst_n     (rst_n),
      .halt      (cfg_wr),
      .launch    (launch),
      .tick      (tick),
      .repeat_en (cfg_mode_q == TMODE_REPEAT),
      .load_val  (cfg_cnt_q),
      .running   (running),
      .remain    (cnt_rd),
      .expire    (expire)
   );

   // R5: expiry pulse lasts one cycle
   a_r5_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      expire |=> !expire);
   // R6: a write halts the timer
   a_r6_write_halts: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_wr |=> (cnt_rd == '0 && !expire));
   // R7: zero count is never launched
   a_r7_zero_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !running && cfg_cnt_q == '0) |=> (cnt_rd == '0 && !expire));
   // R2: a launch presents the programmed count
   a_r2_launch_load: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !cfg_wr && cfg_cnt_q != '0) |=> (cnt_rd == $past(cfg_cnt_q)));
endmodule

// File: tb/expiry_timer_tb_top.sv
module expiry_timer_tb_top;
   localparam int T = 5;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cfg_wr = 1'b0;
   logic [7:0] cfg_data = '0;
   logic       start = 1'b0;
   logic [6:0] cnt_rd;
   logic       expire;

   int n_checks = 0;
   int n_err = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   expiry_timer #(.COUNT_W(7), .TICK_CYCLES(T)) dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_data(cfg_data),
      .start(start), .cnt_rd(cnt_rd), .expire(expire)
   );

   function automatic logic [6:0] exp_rd(int n, bit rep, int c);
      int p = n * T;
      if (rep) return 7'(n - (c % p) / T);
      if (c < p) return 7'(n - c / T);
      return 7'd0;
   endfunction

   function automatic logic exp_irq(int n, bit rep, int c);
      int p = n * T;
      if (c <= 0) return 1'b0;
      if (rep) return (c % p) == 0;
      return c == p;
   endfunction

   task automatic chk(input string tag, input logic [6:0] rd_e, input logic irq_e);
      n_checks++;
      if (cnt_rd !== rd_e || expire !== irq_e) begin
         n_err++;
         $display("FAIL %s: cnt_rd=%0d expire=%0b expected cnt_rd=%0d expire=%0b",
                  tag, cnt_rd, expire, rd_e, irq_e);
      end
   endtask

   task automatic idle_chk(input string tag, input int cycles);
      for (int i = 0; i < cycles; i++) begin
         chk(tag, 7'd0, 1'b0);
         @(negedge clk);
      end
   endtask

   task automatic do_write(input logic [7:0] v);
      cfg_wr = 1'b1; cfg_data = v;
      @(negedge clk);
      cfg_wr = 1'b0;
   endtask

   task automatic do_start();
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic follow(input int n, input bit rep, input int cycles);
      string tag;
      for (int c = 0; c < cycles; c++) begin
         if (exp_irq(n, rep, c)) tag = rep ? "R4" : "R3";
         else if (exp_irq(n, rep, c - 1)) tag = "R5";
         else tag = "R2";
         chk(tag, exp_rd(n, rep, c), exp_irq(n, rep, c));
         @(negedge clk);
      end
   endtask

   task automatic scenario(input int n, input bit rep);
      do_write({rep, 7'(n)});
      idle_chk("R1", 3);
      do_start();
      if (rep) begin
         follow(n, rep, 2 * n * T + T);
         do_write({rep, 7'(n)});
         idle_chk("R6", n * T + T);
      end else begin
         follow(n, rep, n * T + 2 * T);
      end
   endtask

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      idle_chk("R8", 4);

      // directed: shortest single and periodic runs
      scenario(1, 1'b0);
      scenario(1, 1'b1);
      scenario(3, 1'b0);
      scenario(2, 1'b1);

      // R7: zero count never starts
      do_write(8'h80);
      do_start();
      idle_chk("R7", 4 * T);

      // R6: write and start in the same cycle, write wins
      cfg_wr = 1'b1; cfg_data = 8'h02; start = 1'b1;
      @(negedge clk);
      cfg_wr = 1'b0; start = 1'b0;
      idle_chk("R6", 3 * T);
      do_start();
      follow(2, 1'b0, 2 * T + T);

      // R9: restart mid-run reloads and clears the prescaler
      do_write(8'h03);
      do_start();
      follow(3, 1'b0, T + 2);
      do_start();
      follow(3, 1'b0, 3 * T + 2 * T);

      // R6: rewrite halts a single-mode run midway
      do_write(8'h04);
      do_start();
      follow(4, 1'b0, 2 * T + 1);
      do_write(8'h04);
      idle_chk("R6", 4 * T);

      // random
      for (int k = 0; k < 30; k++) begin
         int  n   = 1 + int'($urandom % 8);
         bit  rep = bit'($urandom % 2);
         scenario(n, rep);
      end

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_checks);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_err++;
         n_checks++;
         $display("FAIL watchdog: run did not complete, expected completion");
         $display("Result: errors=%0d of %0d checks", n_err, n_checks);
         $finish;
      end
   end
endmodule